// File: doc/BRIEF.md
# Gated Clock Divider with Duty Control

This block derives a slow sample or frame clock, such as the left/right clock of an audio serial link, from a faster input clock. Software writes two fields. The divider field gives the period of the output, and the high-time field gives how many input cycles of each period the output stays high. The divider field uses zero-based encoding: a stored value `v` makes a period of `v+1` input cycles. The value zero is not a legal ratio. It switches the output off and holds it low.

The output clock is a flop output with no combinational path to it. It restarts at the start of a high phase each time the divider field goes from zero to a nonzero value. When either field changes while the divider runs, the period in progress finishes on its old settings and the new values load at the next period boundary. This prevents runt pulses. A parameter selects between two variants. The adjustable variant stores a high-time field. The fixed variant ignores writes to that field and produces a near-50% waveform.

Top module: `gated_clkdiv`

## Requirements
- R1: When the divider field holds 0, `enabled_o` is 0 and `clk_o` is 0 from the second rising edge after the write onward, and it stays 0.
- R2: With divider value v (1..2^DIV_W-1), `clk_o` has a period of exactly v+1 input cycles.
- R3: In the adjustable variant with high-time h < v, `clk_o` is high for h+1 input cycles and low for v-h cycles in each period.
- R4: If h >= v, the output is high for v cycles and low for the final cycle of each period, so it keeps toggling.
- R5: An all-ones divider value gives the largest ratio, a period of 2^DIV_W input cycles.
- R6: `div_rdata_o` and `hi_rdata_o` return the stored fields from the edge after a write. `enabled_o` is 1 exactly when the divider readback is nonzero.
- R7: Writing a nonzero divider while gated makes `clk_o` rise on the second rising edge after the write edge, which starts a high phase.
- R8: A divider or high-time change made while running does not alter the current period. It takes effect from the next period boundary.
- R9: An asynchronous active-low reset clears both fields, the counter and the output, which leaves the block gated.
- R10: In the fixed variant (HAS_DUTY=0), high-time writes are ignored, `hi_rdata_o` reads 0, and the output is high for floor((v+1)/2) cycles of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_we_i | input | 1 | Divider field write strobe |
| div_wdata_i | input | DIV_W | Divider write value (zero-based, 0 gates) |
| hi_we_i | input | 1 | High-time field write strobe |
| hi_wdata_i | input | DIV_W | High-time write value |
| div_rdata_o | output | DIV_W | Divider field readback |
| hi_rdata_o | output | DIV_W | High-time field readback |
| enabled_o | output | 1 | Divider field is nonzero |
| clk_o | output | 1 | Divided output clock |

## Verification
The embedded assertions check on every cycle that the output stays low while the block is gated and that the counter stays inside the active period. They also check that the output rises only at count zero, that the final cycle of a period is always low, and that the loaded settings cannot change in the middle of a period. Only the bench scenarios can show the actual high and low lengths for specific field values, the clamp, and the restart latency after enabling. They also cover the deferral of a mid-period change across a boundary, reset during operation, and the fixed-duty variant's waveform.

// File: rtl/gated_clkdiv.sv
module gated_clkdiv #(
  parameter int DIV_W    = 8,
  parameter bit HAS_DUTY = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  input  logic             hi_we_i,
  input  logic [DIV_W-1:0] hi_wdata_i,
  output logic [DIV_W-1:0] div_rdata_o,
  output logic [DIV_W-1:0] hi_rdata_o,
  output logic             enabled_o,
  output logic             clk_o
);

  logic [DIV_W-1:0] div_q, hi_q, cur_div, cur_hi, cnt;
  logic             run_q, clk_q;
  logic [DIV_W-1:0] hi_src, hi_lim;
  logic [DIV_W:0]   half;
  logic             gated, boundary;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (div_we_i) div_q <= div_wdata_i;
  end

  generate
    if (HAS_DUTY) begin : g_duty
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hi_q <= '0;
        else if (hi_we_i) hi_q <= hi_wdata_i;
      end
      assign hi_src = hi_q;
      assign half   = '0;
    end else begin : g_fixed
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hi_q <= '0;
        else         hi_q <= '0;
      end
      assign half   = ({1'b0, div_q} + (DIV_W+1)'(1)) >> 1;
      assign hi_src = DIV_W'(half - (DIV_W+1)'(1));
    end
  endgenerate

  assign hi_lim   = (hi_src >= div_q) ? div_q - DIV_W'(1) : hi_src;
  assign gated    = (div_q == '0);
  assign boundary = !run_q || (cnt == cur_div);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cnt     <= '0;
      cur_div <= '0;
      cur_hi  <= '0;
      clk_q   <= 1'b0;
    end else if (gated) begin
      run_q <= 1'b0;
      cnt   <= '0;
      clk_q <= 1'b0;
    end else if (boundary) begin
      run_q   <= 1'b1;
      cnt     <= '0;
      cur_div <= div_q;
      cur_hi  <= hi_lim;
      clk_q   <= 1'b1;
    end else begin
      cnt   <= cnt + DIV_W'(1);
      clk_q <= (cnt < cur_hi);
    end
  end

  assign div_rdata_o = div_q;
  assign hi_rdata_o  = hi_q;
  assign enabled_o   = (div_q != '0);
  assign clk_o       = clk_q;

  assert_gate_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == '0) |=> !clk_o);

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt <= cur_div));

  assert_high_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_o |-> (run_q && cnt <= cur_hi));

  assert_last_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt == cur_div) |-> !clk_o);

  assert_rise_at_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |-> (cnt == '0));

  assert_hold_mid_period_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt != '0) |-> ($stable(cur_div) && $stable(cur_hi)));

endmodule

// File: tb/sim_gated_clkdiv.sv
module sim_gated_clkdiv;
  localparam int W      = 8;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic div_we = 1'b0, hi_we = 1'b0;
  logic [W-1:0] div_wd = '0, hi_wd = '0;
  logic [W-1:0] div_rd0, hi_rd0, div_rd1, hi_rd1;
  logic en0, en1, ck0, ck1;
  int n_tests = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  gated_clkdiv #(.DIV_W(W), .HAS_DUTY(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_we_i(div_we), .div_wdata_i(div_wd),
    .hi_we_i(hi_we), .hi_wdata_i(hi_wd), .div_rdata_o(div_rd0),
    .hi_rdata_o(hi_rd0), .enabled_o(en0), .clk_o(ck0));

  gated_clkdiv #(.DIV_W(W), .HAS_DUTY(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .div_we_i(div_we), .div_wdata_i(div_wd),
    .hi_we_i(hi_we), .hi_wdata_i(hi_wd), .div_rdata_o(div_rd1),
    .hi_rdata_o(hi_rd1), .enabled_o(en1), .clk_o(ck1));

  // {div, hi, expected period, expected high cycles}
  localparam int VEC [0:5][0:3] = '{
    '{1,   0,   2,   1},   // R2 R3 smallest ratio
    '{3,   1,   4,   2},   // R2 R3
    '{7,   0,   8,   1},   // R3 minimal high
    '{5,   5,   6,   5},   // R4 hi == v clamp
    '{6,   9,   7,   6},   // R4 hi > v clamp
    '{255, 100, 256, 101}  // R5 all ones
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_div(input int v);
    @(negedge clk); div_we = 1'b1; div_wd = W'(v);
    @(negedge clk); div_we = 1'b0;
  endtask

  task automatic wr_hi(input int v);
    @(negedge clk); hi_we = 1'b1; hi_wd = W'(v);
    @(negedge clk); hi_we = 1'b0;
  endtask

  function automatic logic sel(input bit which);
    return which ? ck1 : ck0;
  endfunction

  task automatic measure(input bit which, output int hi_n, output int tot);
    int guard = 0;
    logic prev = sel(which);
    hi_n = 0; tot = 0;
    forever begin
      @(negedge clk); guard++;
      if (!prev && sel(which)) break;
      prev = sel(which);
      if (guard > 2000) return;
    end
    hi_n = 1;
    forever begin
      @(negedge clk); guard++;
      if (!sel(which) || guard > 4000) break;
      hi_n++;
    end
    tot = hi_n + 1;
    forever begin
      @(negedge clk); guard++;
      if (sel(which) || guard > 6000) break;
      tot++;
    end
  endtask

  initial begin
    #(PERIOD*200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int h, t;
    #(PERIOD*3);
    @(negedge clk);
    check(div_rd0 == 0 && hi_rd0 == 0, "R9 reset fields", int'(div_rd0), 0);
    check(!en0 && !ck0, "R9 reset gated", int'(ck0), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) begin
      wr_div(0);
      wr_hi(VEC[i][1]);
      wr_div(VEC[i][0]);
      check(int'(div_rd0) == VEC[i][0], "R6 div readback", int'(div_rd0), VEC[i][0]);
      check(int'(hi_rd0) == VEC[i][1], "R6 hi readback", int'(hi_rd0), VEC[i][1]);
      measure(1'b0, h, t);
      check(t == VEC[i][2], "R2 R5 period", t, VEC[i][2]);
      check(h == VEC[i][3], "R3 R4 high cycles", h, VEC[i][3]);
    end

    // R7 restart latency from gated
    wr_div(0);
    wr_hi(1);
    wr_div(4);
    check(en0 == 1'b1, "R6 enabled after write", int'(en0), 1);
    check(ck0 == 1'b0, "R7 low one cycle after write", int'(ck0), 0);
    @(negedge clk);
    check(ck0 == 1'b1, "R7 rise on second edge", int'(ck0), 1);

    // R8 mid-period divider change
    wr_div(3);
    measure(1'b0, h, t);
    check(t == 4, "R8 setup period", t, 4);
    wr_div(5);
    @(negedge clk);
    check(ck0 == 1'b0, "R8 old period still running", int'(ck0), 0);
    @(negedge clk);
    check(ck0 == 1'b1, "R8 old period ends on time", int'(ck0), 1);
    measure(1'b0, h, t);
    check(t == 6, "R8 new period applied", t, 6);
    check(h == 2, "R8 high kept", h, 2);

    // R8 mid-period high-time change
    wr_hi(3);
    measure(1'b0, h, t);
    check(h == 4, "R8 new high time at boundary", h, 4);

    // R1 gating while running
    wr_div(0);
    check(en0 == 1'b0, "R1 enabled clears", int'(en0), 0);
    @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      check(ck0 == 1'b0, "R1 held low", int'(ck0), 0);
      @(negedge clk);
    end

    // R10 fixed-duty variant
    wr_hi(3);
    check(hi_rd1 == 0, "R10 hi write ignored", int'(hi_rd1), 0);
    wr_div(4);
    measure(1'b1, h, t);
    check(t == 5, "R10 period", t, 5);
    check(h == 2, "R10 high floor half", h, 2);
    wr_div(1);
    measure(1'b1, h, t);
    check(t == 2 && h == 1, "R10 smallest ratio", h, 1);

    // R9 reset while running
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(div_rd0 == 0 && hi_rd0 == 0, "R9 fields cleared", int'(hi_rd0), 0);
    check(!ck0 && !en0, "R9 output gated", int'(ck0), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(ck0 == 1'b0, "R9 stays gated after release", int'(ck0), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule